// File: doc/BRIEF.md
# Shadowed Management Register Bank

This block is a management-register slave that places several 10-bit shadow registers behind a single 16-bit register address. Every write to the shared address carries, in its upper bits, a write-enable flag and a 5-bit shadow selector. With the flag set, the low ten bits land in the selected shadow. With the flag clear, nothing is stored and the selector is only remembered as the target of the next read.

One shadow, the spare-control shadow, drives two outputs that control a 125 MHz clock output. The first is a request that keeps the clock output running. The second is an enable for automatic power-down of that clock. The remaining shadows are general-purpose payload storage. Selectors that are not implemented accept writes without effect and read back a zero payload. Access is through a simple parallel port with address, write strobe, write data, read strobe and registered read data.

Top module: `shadow_regbank`

## Requirements
- R1: After reset the read selector is 5 (binary 00101) and the spare-control payload is 0x00F. A read of address 0x1C therefore returns 0x140F, the clock request is high and the auto-power-down enable is low.
- R2: A write to address 0x1C with bit 15 set stores bits 9:0 into the shadow named by bits 14:10. General-purpose shadows sit at selectors 0 to NUM_GP-1 and reset to zero.
- R3: A write to address 0x1C with bit 15 clear changes no shadow payload. It latches bits 14:10 as the read selector.
- R4: A read strobe to address 0x1C loads the read data on the next clock edge. Bit 15 of that data is 0, bits 14:10 hold the latched selector and bits 9:0 hold that shadow's payload.
- R5: Bits 9:2 of the spare-control shadow (selector 5) always read 0x03 and ignore writes. Bits 1:0 are writable.
- R6: A selector with no shadow behind it (for example 10) accepts writes silently and reads back a zero payload.
- R7: When spare-control bit 0 is 0, the clock request output is low.
- R8: When spare-control bit 1 is 0, the auto-power-down enable is high. The clock request is then low while the power-down-mode input is high. When bit 1 is 1, the power-down-mode input has no effect on the clock request.
- R9: Writes to any other address change no state. A read of another address returns 0x0000.
- R10: A write with bit 15 set leaves the latched read selector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Read data, registered |
| pd_mode_i | input | 1 | Power-down mode is active |
| clk125_req_o | output | 1 | Keep the 125 MHz clock output running |
| clk125_apd_en_o | output | 1 | Auto-power-down of the clock output is enabled |

## Verification
A write becomes visible on the clock edge that samples its strobe. The clock request and power-down enable follow combinationally from that stored state, so they are due one edge after the write. Read data is registered and is due on the edge that samples the read strobe. The driver changes inputs on falling edges, and the monitor compares on the falling edge that follows each read cycle, popping its expected word from the scoreboard queue. Output levels are checked on the falling edge after a write, or half a cycle after the power-down input changes.

// File: rtl/shadow_regbank.sv
module shadow_regbank #(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 5,
  parameter int SEL_W      = 5,
  parameter int PAY_W      = 10,
  parameter int NUM_GP     = 4,
  parameter logic [ADDR_W-1:0] SHARED_ADDR = 5'h1C,
  parameter logic [SEL_W-1:0]  SPARE_SEL   = 5'd5,
  parameter logic [PAY_W-3:0]  RSVD_VAL    = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              pd_mode_i,
  output logic              clk125_req_o,
  output logic              clk125_apd_en_o
);
  localparam int WE_BIT  = DATA_W - 1;
  localparam int SEL_LSB = PAY_W;
  localparam int SEL_MSB = PAY_W + SEL_W - 1;

  logic             hit_wr, hit_rd, do_store, do_point;
  logic [SEL_W-1:0] wsel, rd_sel;
  logic [1:0]       spare_q;
  logic [PAY_W-1:0] gp_q [NUM_GP];
  logic [PAY_W-1:0] rd_payload;

  assign hit_wr   = reg_wr && (reg_addr == SHARED_ADDR);
  assign hit_rd   = reg_rd && (reg_addr == SHARED_ADDR);
  assign wsel     = reg_wdata[SEL_MSB:SEL_LSB];
  assign do_store = hit_wr && reg_wdata[WE_BIT];
  assign do_point = hit_wr && !reg_wdata[WE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rd_sel <= SPARE_SEL;
    else if (do_point) rd_sel <= wsel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               spare_q <= 2'b11;
    else if (do_store && wsel == SPARE_SEL)   spare_q <= reg_wdata[1:0];
  end

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              gp_q[g] <= '0;
      else if (do_store && wsel == SEL_W'(g))  gp_q[g] <= reg_wdata[PAY_W-1:0];
    end
  end

  always_comb begin
    rd_payload = '0;
    if (rd_sel == SPARE_SEL) rd_payload = {RSVD_VAL, spare_q};
    for (int i = 0; i < NUM_GP; i++)
      if (rd_sel == SEL_W'(i)) rd_payload = gp_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (hit_rd) reg_rdata <= {1'b0, rd_sel, rd_payload};
    else if (reg_rd) reg_rdata <= '0;
  end

  assign clk125_apd_en_o = !spare_q[1];
  assign clk125_req_o    = spare_q[0] && !(clk125_apd_en_o && pd_mode_i);

  a_r4_rd_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rdata[WE_BIT]);
  a_r4_rd_sel_echo: assert property (@(posedge clk) disable iff (!rst_n)
    hit_rd |=> reg_rdata[SEL_MSB:SEL_LSB] == $past(rd_sel));
  a_r5_rsvd_const: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_rd && rd_sel == SPARE_SEL) |=> reg_rdata[PAY_W-1:2] == RSVD_VAL);
  a_r3_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_wdata[WE_BIT]) |=> $stable(spare_q));
  a_r10_sel_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[WE_BIT]) |=> $stable(rd_sel));
  a_r9_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr != SHARED_ADDR) |=> ($stable(rd_sel) && $stable(spare_q)));
  a_r7_clk_off: assert property (@(posedge clk) disable iff (!rst_n)
    !spare_q[0] |-> !clk125_req_o);
  a_r8_pd_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (spare_q == 2'b11) |-> clk125_req_o);
endmodule

// File: tb/shadow_regbank_tb.sv
`timescale 1ns/1ps
module shadow_regbank_tb_top;
  logic        clk = 0, rst_n = 0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 0, reg_rd = 0, pd_mode_i = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        clk125_req_o, clk125_apd_en_o;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic        rd_d = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  shadow_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .pd_mode_i(pd_mode_i), .clk125_req_o(clk125_req_o),
    .clk125_apd_en_o(clk125_apd_en_o));

  always @(posedge clk) rd_d <= reg_rd;

  always @(negedge clk) begin
    if (rd_d) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (reg_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: rdata actual %h expected %h", t, reg_rdata, e);
      end
    end
  end

  task automatic chk(input string t, input logic a, input logic e);
    n_cmp++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", t, a, e);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    reg_addr = a; reg_rd = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    reg_rd = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 clk req", clk125_req_o, 1'b1);
    chk("R1 apd en", clk125_apd_en_o, 1'b0);
    rd(5'h1C, 16'h140F, "R1 reset read");
    wr(5'h1C, 16'h82A5);
    wr(5'h1C, 16'h0000);
    rd(5'h1C, 16'h02A5, "R2 R4 gp0");
    wr(5'h1C, 16'h8D55);
    rd(5'h1C, 16'h02A5, "R10 sel kept");
    wr(5'h1C, 16'h0C00);
    rd(5'h1C, 16'h0D55, "R2 gp3");
    wr(5'h1C, 16'h0FFF);
    rd(5'h1C, 16'h0D55, "R3 no store");
    wr(5'h1C, 16'hABFF);
    wr(5'h1C, 16'h2800);
    rd(5'h1C, 16'h2800, "R6 unimpl sel");
    wr(5'h1C, 16'h97F0);
    chk("R7 clk req off", clk125_req_o, 1'b0);
    chk("R8 apd en", clk125_apd_en_o, 1'b1);
    wr(5'h1C, 16'h1400);
    rd(5'h1C, 16'h140C, "R5 reserved");
    wr(5'h1C, 16'h9401);
    chk("R8 pd low req", clk125_req_o, 1'b1);
    pd_mode_i = 1; #0.5;
    chk("R8 pd high req", clk125_req_o, 1'b0);
    wr(5'h1C, 16'h9403);
    chk("R8 pd masked", clk125_req_o, 1'b1);
    chk("R8 apd off", clk125_apd_en_o, 1'b0);
    wr(5'h1B, 16'h9400);
    chk("R9 other write", clk125_req_o, 1'b1);
    rd(5'h1B, 16'h0000, "R9 other read");
    rd(5'h1C, 16'h140F, "R9 state kept");
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule